// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer. It runs on a fast input clock that stands in for the oscillator being divided. Inside it is a behavioural prescaler whose cycle length is either 2^P_W or 2^P_W+1 input clocks (32 or 33 with the defaults). A swallow count A and a main count B decide how many prescaler cycles of each length make up one output period. The block emits one output pulse every N = 32·B + A input clocks. It also drives the modulus-control signal that selects the long prescaler cycle. This lets any integer ratio be reached without a programmable counter running at the full input rate.

A and B arrive through a write strobe into a pending latch. A legal setting is held there until the current output period ends, and the new ratio starts with the next period. An illegal setting is refused, the running ratio stays as it was, and an error flag rises. For example, a 1.2 GHz output locked to a 400 kHz reference needs N = 3000, which is B = 93 and A = 24.

Top module: `swallow_divider`

## Requirements
- R1: While a setting (A, B) is active, `div_out` is high for exactly one input clock once every 32·B + A input clocks.
- R2: Within each output period, `mod_ctl` is high for the first 33·A input clocks (the A long prescaler cycles) and low for the remaining 32·(B−A) clocks.
- R3: The setting B = 93, A = 24 gives an output period of 3000 input clocks, with `mod_ctl` high for 792 of them.
- R4: A legal write does not alter the period in progress. The new ratio applies from the output period that starts after the next `div_out`-producing boundary.
- R5: A write with B < 3 or B ≤ A is refused and leaves the running and pending ratios unchanged. `cfg_err` is 1 from the clock after such a write and returns to 0 on the clock after the next legal write.
- R6: While `rst` is high at a clock edge, the counters clear, any pending setting is dropped, the ratio returns to the default (A = 0, B = 3), and `div_out`, `cfg_err` and `mod_ctl` read 0. The first `div_out` pulse is high after the 96th clock edge following release.
- R7: When several legal writes land within one output period, only the last one takes effect at the boundary.
- R8: With A = 0, `mod_ctl` stays low for the whole output period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | One-clock strobe that offers `cfg_a`/`cfg_b` to the pending latch |
| cfg_a | input | A_W | Swallow count A |
| cfg_b | input | B_W | Main count B |
| div_out | output | 1 | One-clock pulse per output period |
| mod_ctl | output | 1 | 1 selects the long (33) prescaler cycle, 0 the short (32) one |
| cfg_err | output | 1 | Set by a refused write, cleared by a legal write |

## Verification
The assertions assume `cfg_wr` is sampled only when `cfg_a` and `cfg_b` hold settled values. They also assume that the shortest legal period, 96 clocks, always exceeds one clock, so a pulse can never be followed directly by another. The stimulus drives all inputs on the falling clock edge and holds each write strobe for exactly one cycle. It places writes away from boundaries and also right after a pulse, which keeps every setting change inside a single, well-defined output period. A behavioural model that tracks only the position within the period is compared against `div_out`, `mod_ctl` and `cfg_err` on every clock. Separate measurements of the pulse spacing and of the count of long prescaler cycles confirm the period lengths.

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int P_W   = 5,
  parameter int A_W   = 5,
  parameter int B_W   = 8,
  parameter int B_MIN = 3,
  parameter int DEF_A = 0,
  parameter int DEF_B = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic [A_W-1:0] cfg_a,
  input  logic [B_W-1:0] cfg_b,
  output logic           div_out,
  output logic           mod_ctl,
  output logic           cfg_err
);
  localparam int PC_W = P_W + 1;
  localparam logic [PC_W-1:0] LONG_LAST  = PC_W'(2**P_W);
  localparam logic [PC_W-1:0] SHORT_LAST = PC_W'(2**P_W - 1);

  logic [PC_W-1:0] pc;
  logic [B_W-1:0]  b_idx, cur_b, pend_b;
  logic [A_W-1:0]  cur_a, pend_a;
  logic            pend_v;

  wire cfg_ok  = (cfg_b >= B_W'(B_MIN)) && (cfg_b > B_W'(cfg_a));
  assign mod_ctl = b_idx < B_W'(cur_a);
  wire pre_end = pc == (mod_ctl ? LONG_LAST : SHORT_LAST);
  wire term    = pre_end && (b_idx == cur_b - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      b_idx   <= '0;
      cur_a   <= A_W'(DEF_A);
      cur_b   <= B_W'(DEF_B);
      pend_a  <= A_W'(DEF_A);
      pend_b  <= B_W'(DEF_B);
      pend_v  <= 1'b0;
      cfg_err <= 1'b0;
      div_out <= 1'b0;
    end else begin
      div_out <= term;
      pc      <= pre_end ? '0 : pc + 1'b1;
      if (term) begin
        b_idx <= '0;
        if (pend_v) begin
          cur_a  <= pend_a;
          cur_b  <= pend_b;
          pend_v <= 1'b0;
        end
      end else if (pre_end) begin
        b_idx <= b_idx + 1'b1;
      end
      if (cfg_wr) begin
        if (cfg_ok) begin
          pend_a  <= cfg_a;
          pend_b  <= cfg_b;
          pend_v  <= 1'b1;
          cfg_err <= 1'b0;
        end else begin
          cfg_err <= 1'b1;
        end
      end
    end
  end

  p_pulse_single_r1: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out);

  p_mod_rise_at_boundary_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_ctl) |-> div_out);

  p_hold_setting_r4: assert property (@(posedge clk) disable iff (rst)
    !div_out |-> ($stable(cur_a) && $stable(cur_b)));

  p_illegal_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_ok) |=> cfg_err);

  p_active_legal_r5: assert property (@(posedge clk) disable iff (rst)
    (cur_b >= B_W'(B_MIN)) && (cur_b > B_W'(cur_a)));

  p_reset_quiet_r6: assert property (@(posedge clk)
    rst |=> (!div_out && !cfg_err && !mod_ctl));
endmodule

// File: tb/swallow_divider_tb.sv
module swallow_divider_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [4:0] cfg_a = '0;
  logic [7:0] cfg_b = '0;
  logic       div_out, mod_ctl, cfg_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  swallow_divider dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .div_out(div_out), .mod_ctl(mod_ctl), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural model: position inside the output period
  int m_pos = 0, m_ca = 0, m_cb = 3, m_pa = 0, m_pb = 3;
  bit m_pv = 0, m_err = 0, m_div = 0, m_started = 0, m_rstq = 1;

  always @(posedge clk) begin
    cyc++;
    m_started = 1;
    m_rstq = rst;
    if (rst) begin
      m_pos = 0; m_ca = 0; m_cb = 3; m_pv = 0; m_err = 0; m_div = 0;
    end else begin
      m_div = (m_pos == 32 * m_cb + m_ca - 1);
      if (m_div) begin
        m_pos = 0;
        if (m_pv) begin m_ca = m_pa; m_cb = m_pb; m_pv = 0; end
      end else begin
        m_pos++;
      end
      if (cfg_wr) begin
        if (int'(cfg_b) >= 3 && int'(cfg_b) > int'(cfg_a)) begin
          m_pa = cfg_a; m_pb = cfg_b; m_pv = 1; m_err = 0;
        end else begin
          m_err = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (m_started) begin
      chk("R1", "div_out vs model", int'(div_out), int'(m_div));
      chk("R2", "mod_ctl vs model", int'(mod_ctl), int'(m_pos < 33 * m_ca));
      chk("R5", "cfg_err vs model", int'(cfg_err), int'(m_err));
    end
  end

  // Pulse spacing and long-cycle count per output period
  int cnt = 0, last_gap = 0, npulse = 0, modcnt = 0, last_mod = 0;
  always @(negedge clk) begin
    if (m_rstq) begin
      cnt = 0; modcnt = 0;
    end else begin
      cnt++;
      if (div_out) begin
        last_gap = cnt; cnt = 0;
        last_mod = modcnt; modcnt = int'(mod_ctl);
        npulse++;
      end else begin
        modcnt += int'(mod_ctl);
      end
    end
  end

  task automatic do_write(input int a, input int b);
    @(negedge clk);
    cfg_a = 5'(a); cfg_b = 8'(b); cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic next_pulse();
    int t;
    t = npulse + 1;
    wait (npulse >= t);
  endtask

  task automatic run();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6", "div_out in reset", int'(div_out), 0);
    chk("R6", "cfg_err in reset", int'(cfg_err), 0);
    chk("R6", "mod_ctl in reset", int'(mod_ctl), 0);
    rst = 1'b0;
    next_pulse(); chk("R6", "first gap after release", last_gap, 96);
    next_pulse(); chk("R1", "default period", last_gap, 96);

    do_write(24, 93);
    next_pulse(); chk("R4", "period in progress kept", last_gap, 96);
    next_pulse(); chk("R3", "N=3000 period", last_gap, 3000);
    chk("R3", "long cycles clocks", last_mod, 792);
    next_pulse(); chk("R3", "N=3000 repeat", last_gap, 3000);

    do_write(3, 4);
    next_pulse(); chk("R4", "old ratio until boundary", last_gap, 3000);
    next_pulse(); chk("R1", "N=131 period", last_gap, 131);
    chk("R2", "mod clocks A=3", last_mod, 99);

    do_write(0, 2);  chk("R5", "flag after B<3", int'(cfg_err), 1);
    do_write(5, 5);  chk("R5", "flag after B==A", int'(cfg_err), 1);
    do_write(7, 5);  chk("R5", "flag after B<A", int'(cfg_err), 1);
    next_pulse(); chk("R5", "period unchanged", last_gap, 131);
    next_pulse(); chk("R5", "period still unchanged", last_gap, 131);

    do_write(1, 6);  chk("R5", "flag cleared by legal write", int'(cfg_err), 0);
    next_pulse(); next_pulse(); chk("R1", "N=193 period", last_gap, 193);

    do_write(2, 10);
    do_write(0, 7);
    next_pulse(); chk("R7", "old ratio kept", last_gap, 193);
    next_pulse(); chk("R7", "last write wins", last_gap, 224);
    chk("R8", "mod low with A=0", last_mod, 0);

    do_write(31, 255);
    next_pulse(); next_pulse(); chk("R1", "max period", last_gap, 8191);
    chk("R2", "mod clocks A=31", last_mod, 1023);

    do_write(1, 6);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6", "div_out in mid-run reset", int'(div_out), 0);
    rst = 1'b0;
    next_pulse(); chk("R6", "default after reset", last_gap, 96);
    next_pulse(); chk("R6", "pending dropped by reset", last_gap, 96);
  endtask

  initial begin
    fork
      run();
      begin
        wait (cyc > 150000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule